// File: doc/BRIEF.md
# Two-Region Flash Erase Range Sequencer

This block turns one erase request, a start byte address and a byte length, into a run of single-block erase commands for a flash array. The array has two regions with different erase granularity. The lower region holds eight 16 KiB blocks and ends at 0x20000. The upper region follows it directly and holds thirty-one 128 KiB blocks, so the device spans 0x400000 bytes.

The sequencer checks the request before it touches the array. The end address must stay inside the device. The start must sit on a block edge of the region that contains it. The end must sit on a block edge of the region that contains the end. A request that passes is walked in ascending address order. Each block address goes to a downstream command engine over a valid/ready pair. The sequencer then waits for that engine's completion before it sends the next block, so one block is in flight at a time. The step is 16 KiB while the address is below the region boundary and 128 KiB from the boundary upward, which means the step grows part-way through a range that crosses it. The first failed completion ends the run.

The controller has six named states. ST_IDLE takes a request when req_valid is high. ST_CHECK judges the captured request and goes to ST_FINISH for a zero length, to ST_ABORT for an invalid request, or to ST_ISSUE otherwise. ST_ISSUE presents the block and moves to ST_WAIT on blk_ready. ST_WAIT moves on when cmp_valid arrives. A failed completion sends it to ST_ABORT. A good completion sends it to ST_ISSUE, or to ST_FINISH when the advanced address equals the end. ST_FINISH and ST_ABORT each last one cycle and then return to ST_IDLE.

Top module: `erase_range_seq`

## Requirements
- R1: After reset the block is idle: req_ready=1, busy=0, blk_valid=0, done=0, error=0.
- R2: A request is taken only on a clock edge where req_ready=1 and req_valid=1. busy is 1 from the next cycle until the cycle of the done or error pulse, and it is 0 in the cycle after that pulse. A req_valid that arrives while busy=1 changes neither the block sequence nor the outcome.
- R3: A request with req_len=0 ends with a done pulse and issues no block, whatever its start address.
- R4: A request is rejected when start+len, computed without wrap-around, is greater than 0x400000. A rejected request issues no block, raises error, and sets err_cause=0.
- R5: A request is rejected (error, err_cause=0, no block) when its start is not a multiple of its region's block size. The block size is 16 KiB for addresses below 0x20000 and 128 KiB at or above 0x20000.
- R6: A request is rejected (error, err_cause=0, no block) when start+len is not a multiple of the block size of the region that start+len falls in. An end equal to 0x20000 counts as the upper region.
- R7: Block addresses are issued in ascending order, beginning at start. Each step is 16 KiB below 0x20000 and 128 KiB at or above it. blk_region is 0 for lower-region blocks and 1 for upper-region blocks.
- R8: While blk_valid=1 and blk_ready=0, blk_valid stays 1 and blk_addr does not change. No new block is presented between blk_ready and the matching cmp_valid.
- R9: A completion with cmp_fail=1 ends the run. The sequencer issues no further block, raises error, and sets err_cause=1.
- R10: When every block completes without failure, done pulses in the cycle after the last cmp_valid.
- R11: done and error are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_start | input | AW | Start byte address |
| req_len | input | AW | Length in bytes |
| blk_valid | output | 1 | Block erase command present |
| blk_ready | input | 1 | Command engine takes the block |
| blk_addr | output | AW | Base byte address of the block |
| blk_region | output | 1 | 0 for a lower-region block, 1 for an upper-region block |
| cmp_valid | input | 1 | Command engine finished the outstanding block |
| cmp_fail | input | 1 | The finished block failed (valid with cmp_valid) |
| busy | output | 1 | A request is being handled |
| done | output | 1 | One-cycle pulse: request completed |
| error | output | 1 | One-cycle pulse: request rejected or a block failed |
| err_cause | output | 1 | 0 = rejected, 1 = block failure (valid with error) |

## Verification
The bench targets the region boundary. A range from 0x18000 to 0x40000 must switch from a 16 KiB step to a 128 KiB step exactly at 0x20000. A design that keeps the start region's step would issue extra blocks, and one that switches early would skip some. A range whose end is 16 KiB-aligned but lands at 0x24000 in the upper region is accepted by a design that checks the end against the start's region, so the bench expects a rejection there. A length that wraps 32 bits back to exactly 0x100000000 catches an overflow compare that drops the carry. A range ending exactly at 0x20000 or exactly at the device end catches off-by-one errors in both the end test and the region test. The failure case requires that nothing follows the failed block. The bench also sends a second request while the sequencer is busy, which catches a design that restarts or accepts it.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH,
        ST_ABORT
    } seq_state_e;

    typedef enum logic {
        CAUSE_REJECT = 1'b0,
        CAUSE_BLOCK  = 1'b1
    } fail_cause_e;

endpackage

// File: rtl/ers_region_lookup.sv
module ers_region_lookup #(
    parameter int              AW          = 32,
    parameter longint unsigned BOUNDARY    = 64'h20000,
    parameter longint unsigned SMALL_BYTES = 64'h4000,
    parameter longint unsigned LARGE_BYTES = 64'h20000
) (
    input  logic [AW:0] addr,
    output logic [AW:0] step
);
    localparam logic [AW:0] BOUND_V = BOUNDARY[AW:0];
    localparam logic [AW:0] SMALL_V = SMALL_BYTES[AW:0];
    localparam logic [AW:0] LARGE_V = LARGE_BYTES[AW:0];

    // A single comparator against the fixed region edge picks the block size.
    always_comb begin
        if (addr >= BOUND_V) begin
            step = LARGE_V;
        end else begin
            step = SMALL_V;
        end
    end
endmodule

// File: rtl/ers_req_check.sv
module ers_req_check #(
    parameter int              AW          = 32,
    parameter longint unsigned TOTAL       = 64'h400000,
    parameter longint unsigned BOUNDARY    = 64'h20000,
    parameter longint unsigned SMALL_BYTES = 64'h4000,
    parameter longint unsigned LARGE_BYTES = 64'h20000
) (
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] len,
    output logic [AW:0]   end_addr,
    output logic          zero_len,
    output logic          bad
);
    localparam logic [AW:0] TOTAL_V = TOTAL[AW:0];
    localparam int          NPROBE  = 2;

    logic [AW:0]       probe      [NPROBE];
    logic [AW:0]       probe_step [NPROBE];
    logic [NPROBE-1:0] misal;
    logic              overflow;

    // The sum carries into bit AW, so a wrap-around never looks small.
    assign end_addr = {1'b0, start} + {1'b0, len};
    assign probe[0] = {1'b0, start};
    assign probe[1] = end_addr;

    // Each end of the range is aligned against its own region's block size.
    for (genvar g = 0; g < NPROBE; g++) begin : g_probe
        ers_region_lookup #(
            .AW         (AW),
            .BOUNDARY   (BOUNDARY),
            .SMALL_BYTES(SMALL_BYTES),
            .LARGE_BYTES(LARGE_BYTES)
        ) u_lookup (
            .addr(probe[g]),
            .step(probe_step[g])
        );
        assign misal[g] = |(probe[g] & (probe_step[g] - (AW+1)'(1)));
    end

    assign overflow = end_addr > TOTAL_V;
    assign zero_len = (len == '0);
    assign bad      = overflow | (|misal);
endmodule

// File: rtl/ers_fsm.sv
module ers_fsm
    import erase_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_len,
    output logic          req_ready,
    output logic [AW-1:0] start_q,
    output logic [AW-1:0] len_q,
    input  logic [AW:0]   chk_end,
    input  logic          chk_zero,
    input  logic          chk_bad,
    output logic [AW-1:0] cur_addr,
    input  logic [AW:0]   cur_step,
    output logic          blk_valid,
    input  logic          blk_ready,
    input  logic          cmp_valid,
    input  logic          cmp_fail,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          err_cause
);
    seq_state_e  state_q, state_d;
    fail_cause_e cause_q;
    logic [AW-1:0] cur_q;
    logic [AW:0]   end_q;
    logic [AW:0]   nxt_addr;

    assign nxt_addr = {1'b0, cur_q} + cur_step;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (chk_zero)     state_d = ST_FINISH;
                else if (chk_bad) state_d = ST_ABORT;
                else              state_d = ST_ISSUE;
            end
            ST_ISSUE:  if (blk_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (cmp_valid) begin
                    if (cmp_fail)              state_d = ST_ABORT;
                    else if (nxt_addr == end_q) state_d = ST_FINISH;
                    else                        state_d = ST_ISSUE;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_ABORT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= '0;
            len_q   <= '0;
            cur_q   <= '0;
            end_q   <= '0;
            cause_q <= CAUSE_REJECT;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        start_q <= req_start;
                        len_q   <= req_len;
                    end
                end
                ST_CHECK: begin
                    cur_q <= start_q;
                    end_q <= chk_end;
                    if (!chk_zero && chk_bad) cause_q <= CAUSE_REJECT;
                end
                ST_WAIT: begin
                    if (cmp_valid) begin
                        if (cmp_fail) cause_q <= CAUSE_BLOCK;
                        else          cur_q   <= nxt_addr[AW-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q != ST_IDLE);
        blk_valid = (state_q == ST_ISSUE);
        done      = (state_q == ST_FINISH);
        error     = (state_q == ST_ABORT);
        err_cause = cause_q;
        cur_addr  = cur_q;
    end

    // R8
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !blk_ready) |=> (blk_valid && $stable(cur_addr)));

    // R8
    no_issue_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_ready) |=> !blk_valid);

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || error));

    // R9
    stop_after_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (!blk_valid && !busy));
endmodule

// File: rtl/erase_range_seq.sv
module erase_range_seq #(
    parameter int              AW          = 32,
    parameter longint unsigned PARAM_BYTES = 64'h4000,
    parameter longint unsigned PARAM_COUNT = 8,
    parameter longint unsigned MAIN_BYTES  = 64'h20000,
    parameter longint unsigned MAIN_COUNT  = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_len,
    output logic          blk_valid,
    input  logic          blk_ready,
    output logic [AW-1:0] blk_addr,
    output logic          blk_region,
    input  logic          cmp_valid,
    input  logic          cmp_fail,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          err_cause
);
    localparam longint unsigned BOUNDARY = PARAM_BYTES * PARAM_COUNT;
    localparam longint unsigned TOTAL    = BOUNDARY + MAIN_BYTES * MAIN_COUNT;
    localparam logic [AW:0]     LARGE_V  = MAIN_BYTES[AW:0];

    logic [AW-1:0] start_q, len_q, cur_addr;
    logic [AW:0]   chk_end, cur_step;
    logic          chk_zero, chk_bad;

    ers_req_check #(
        .AW         (AW),
        .TOTAL      (TOTAL),
        .BOUNDARY   (BOUNDARY),
        .SMALL_BYTES(PARAM_BYTES),
        .LARGE_BYTES(MAIN_BYTES)
    ) u_check (
        .start   (start_q),
        .len     (len_q),
        .end_addr(chk_end),
        .zero_len(chk_zero),
        .bad     (chk_bad)
    );

    ers_region_lookup #(
        .AW         (AW),
        .BOUNDARY   (BOUNDARY),
        .SMALL_BYTES(PARAM_BYTES),
        .LARGE_BYTES(MAIN_BYTES)
    ) u_cur_lookup (
        .addr({1'b0, cur_addr}),
        .step(cur_step)
    );

    ers_fsm #(.AW(AW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_start(req_start),
        .req_len  (req_len),
        .req_ready(req_ready),
        .start_q  (start_q),
        .len_q    (len_q),
        .chk_end  (chk_end),
        .chk_zero (chk_zero),
        .chk_bad  (chk_bad),
        .cur_addr (cur_addr),
        .cur_step (cur_step),
        .blk_valid(blk_valid),
        .blk_ready(blk_ready),
        .cmp_valid(cmp_valid),
        .cmp_fail (cmp_fail),
        .busy     (busy),
        .done     (done),
        .error    (error),
        .err_cause(err_cause)
    );

    assign blk_addr   = cur_addr;
    assign blk_region = (cur_step == LARGE_V);

    // R7
    blk_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (({1'b0, blk_addr} & (cur_step - (AW+1)'(1))) == '0));

    // R7
    blk_in_device_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> ({1'b0, blk_addr} < TOTAL[AW:0]));
endmodule

// File: tb/erase_range_seq_tb_top.sv
module erase_range_seq_tb_top;
    localparam int          AW    = 32;
    localparam logic [31:0] BOUND = 32'h20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_len = '0;
    logic          blk_valid;
    logic          blk_ready = 1'b0;
    logic [AW-1:0] blk_addr;
    logic          blk_region;
    logic          cmp_valid = 1'b0;
    logic          cmp_fail = 1'b0;
    logic          busy, done, error, err_cause;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    logic [31:0] fail_addr = '0;
    bit          fail_en = 1'b0;
    int          blk_seen = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    erase_range_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_len(req_len), .blk_valid(blk_valid),
        .blk_ready(blk_ready), .blk_addr(blk_addr), .blk_region(blk_region),
        .cmp_valid(cmp_valid), .cmp_fail(cmp_fail), .busy(busy), .done(done),
        .error(error), .err_cause(err_cause)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Downstream engine model and block monitor (scoreboard pop side).
    initial begin
        forever begin
            @(negedge clk);
            if (blk_valid) begin
                logic [31:0] a;
                logic [31:0] e;
                int stall;
                a = blk_addr;
                stall = blk_seen % 3;
                blk_seen++;
                for (int i = 0; i < stall; i++) begin
                    @(negedge clk);
                    check(blk_valid && blk_addr == a, "R8", "held request", blk_addr, a);
                end
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected block", a, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(a == e, "R7", "block address", a, e);
                end
                check(blk_region == (a >= BOUND), "R7", "block region", blk_region, a >= BOUND);
                blk_ready = 1'b1;
                @(negedge clk);
                blk_ready = 1'b0;
                for (int i = 0; i < 2; i++) begin
                    check(!blk_valid, "R8", "no block before completion", blk_valid, 0);
                    @(negedge clk);
                end
                cmp_valid = 1'b1;
                cmp_fail  = fail_en && (a == fail_addr);
                @(negedge clk);
                cmp_valid = 1'b0;
                cmp_fail  = 1'b0;
            end
        end
    end

    // kind: 0 done, 1 rejected, 2 block failure
    task automatic run_req(input logic [31:0] s, input logic [31:0] l, input int kind,
                           input bit poke, input string req);
        longint unsigned a, fin;
        int cnt;
        exp_q.delete();
        if (kind != 1 && l != 0) begin
            a = s;
            fin = longint'(s) + longint'(l);
            while (a < fin) begin
                exp_q.push_back(a[31:0]);
                if (kind == 2 && a[31:0] == fail_addr) break;
                a += (a < BOUND) ? 64'h4000 : 64'h20000;
            end
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_start = s;
        req_len   = l;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, {req, "/R2"}, "busy after accept", busy, 1);
        check(req_ready == 1'b0, "R2", "not ready while busy", req_ready, 0);
        if (poke) begin
            req_valid = 1'b1;
            req_start = 32'h0;
            req_len   = 32'h4000;
            @(negedge clk);
            req_valid = 1'b0;
        end
        cnt = 0;
        while (!(done || error) && cnt < 5000) begin
            check(busy == 1'b1, "R2", "busy until pulse", busy, 1);
            @(negedge clk);
            cnt++;
        end
        check(done == (kind == 0), req, "done", done, kind == 0);
        check(error == (kind != 0), req, "error", error, kind != 0);
        if (kind != 0) check(err_cause == (kind == 2), req, "err_cause", err_cause, kind == 2);
        check(exp_q.size() == 0, req, "blocks left unissued", exp_q.size(), 0);
        @(negedge clk);
        check(!done && !error, "R11", "pulse single cycle", {done, error}, 0);
        check(!busy && req_ready, "R2", "idle after pulse", busy, 0);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0 && !blk_valid, "R9", "quiet after end", blk_valid, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WATCHDOG", "timeout", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(!busy && !blk_valid && !done && !error, "R1", "idle outputs",
              {busy, blk_valid, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_req(32'h12345, 32'h0, 0, 0, "R3");                 // zero length
        run_req(32'h4000, 32'h4000, 0, 0, "R7");               // one small block
        run_req(32'h18000, 32'h28000, 0, 1, "R7");             // crosses the edge, poke R2
        run_req(32'h0, 32'h20000, 0, 0, "R6");                 // ends on the edge
        run_req(32'h0, 32'h400000, 0, 1, "R10");               // whole device
        run_req(32'h3E0000, 32'h20000, 0, 0, "R4");            // ends at device end
        run_req(32'h3E0000, 32'h40000, 1, 0, "R4");            // past device end
        run_req(32'h20000, 32'hFFFE0000, 1, 0, "R4");          // wraps 32 bits
        run_req(32'h24000, 32'h20000, 1, 0, "R5");             // misaligned upper start
        run_req(32'h2000, 32'h2000, 1, 0, "R5");               // misaligned lower start
        run_req(32'h10000, 32'h14000, 1, 0, "R6");             // end 0x24000
        fail_addr = 32'h20000;
        fail_en = 1'b1;
        run_req(32'h0, 32'h60000, 2, 0, "R9");                 // fails at the edge
        fail_en = 1'b0;
        run_req(32'h8000, 32'h8000, 0, 0, "R10");              // recovers after failure
        summary();
    end
endmodule